// File: doc/BRIEF.md
# E1 Test Pattern Generator with Framed and Unframed Modes

The block produces a 2^15-1 pseudo-random test bit stream for one E1 transmit path. One serial bit is produced for each cycle in which the bit-clock enable is high. A mode input selects how the stream is placed. In unframed mode every bit position carries the pseudo-random sequence. In framed mode the block tracks a 256-bit frame of 32 timeslots of 8 bits each. During the 8 bits of timeslot 0 it sends a fixed placeholder and raises a flag, so that a downstream framer can insert its alignment and CRC-4 words there.

The sequence generator is frozen while timeslot 0 is sent. It resumes in timeslot 1, so a receiver that takes out timeslots 1 to 31 sees one unbroken sequence. Frame alignment comes from a frame-start pulse. When there is no such pulse, the position counter wraps by itself every 256 bits.

Top module: `prbs_tx_pattern_gen`

## Requirements
- R1: During reset and after it, until the first enabled bit, tx_bit and ts0_flag are 0. The generator register resets to all ones.
- R2: Both outputs are registered. They change only in the cycle after a cycle with bit_en high, and they hold their value through every cycle with bit_en low.
- R3: With framed_mode low, the successive bits follow x^15 + x^14 + 1 in Fibonacci form. The register shifts toward its MSB, the new bit 0 is bit14 XOR bit13, and each emitted bit is bit14 taken before the shift. The first bit after reset is 1.
- R4: With framed_mode high, the bits at frame positions 0 to 7 (timeslot 0) are sent as 1 and ts0_flag is 1.
- R5: With framed_mode high, the generator does not advance during timeslot 0. The payload bits of positions 8 to 255 across successive frames form the same continuous sequence as in R3.
- R6: The frame position is 0 after reset and rises by one on each enabled bit, wrapping from 255 to 0. A frame_start pulse on an enabled cycle makes that bit position 0. frame_start on a cycle with bit_en low has no effect.
- R7: With framed_mode low, ts0_flag is 0 after every enabled bit.
- R8: The generator never holds all zeros. In unframed mode the stream repeats after exactly 32767 bits, and it contains 16384 ones in each period.
- R9: framed_mode is sampled on each enabled bit. A change applies from the next enabled bit, and the position counter keeps running in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| framed_mode | input | 1 | 0 selects unframed, 1 selects framed with timeslot 0 reserved |
| bit_en | input | 1 | Bit-clock enable, one bit per high cycle |
| frame_start | input | 1 | Marks the current enabled bit as frame position 0 |
| tx_bit | output | 1 | Serial test bit |
| ts0_flag | output | 1 | High while the current bit is a timeslot-0 placeholder in framed mode |

## Verification
On every cycle, the assertions check that the outputs hold between enables, that the generator never sits at zero, and that it freezes whenever it is not allowed to advance. They also check that a flagged bit is always 1, that the flag stays low in unframed mode, and that a frame-start pulse sets the position. Only the bench scenarios can show that the bit values follow the polynomial, that the sequence runs on unbroken across reserved timeslots, that the period is 32767 with the right ones count, and that mode changes take effect at the correct bit. The bench compares every output bit against an arithmetic model through a full unframed period, several framed frames, mid-frame realignment, gaps in the enable, and mode switches.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
    typedef struct packed {
        logic bit_v;
        logic ts0;
    } tx_out_t;

    localparam tx_out_t TX_OUT_RESET = '{bit_v: 1'b0, ts0: 1'b0};
endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
    parameter int W   = 15,
    parameter int TAP = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic msb
);
    localparam logic [W-1:0] SEED = '1;

    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_state_t;

    lfsr_state_t st_d, st_q;
    logic        fb;

    always_comb begin
        st_d = st_q;
        fb   = st_q.sr[W-1] ^ st_q.sr[TAP-1];
        if (advance) begin
            st_d.sr = {st_q.sr[W-2:0], fb};
        end
        if (st_d.sr == '0) begin
            st_d.sr = SEED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign msb = st_q.sr[W-1];

    // R8: the register is never left at zero
    a_r8_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sr != '0);

    // R5: no step unless advance was requested
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(st_q.sr));
endmodule

// File: rtl/prbs_slot_timer.sv
module prbs_slot_timer #(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic frame_start,
    output logic in_ts0
);
    localparam int FRAME_BITS = SLOTS * SLOT_BITS;
    localparam int PW         = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [PW-1:0] pos;
    } tmr_state_t;

    tmr_state_t    st_d, st_q;
    logic [PW-1:0] pos_cur;

    always_comb begin
        st_d    = st_q;
        pos_cur = (bit_en && frame_start) ? '0 : st_q.pos;
        in_ts0  = (pos_cur < PW'(SLOT_BITS));
        if (bit_en) begin
            if (pos_cur == PW'(FRAME_BITS - 1)) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = pos_cur + PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pos <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a frame-start pulse on an enabled bit sets the position
    a_r6_realign: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frame_start) |=> (st_q.pos == PW'(1)));

    // R6: the position holds while the enable is low
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(st_q.pos));
endmodule

// File: rtl/prbs_tx_pattern_gen.sv
module prbs_tx_pattern_gen #(
    parameter int LFSR_W    = 15,
    parameter int LFSR_TAP  = 14,
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic framed_mode,
    input  logic bit_en,
    input  logic frame_start,
    output logic tx_bit,
    output logic ts0_flag
);
    import prbs_pkg::*;

    logic    in_ts0;
    logic    payload;
    logic    advance;
    logic    gen_msb;
    tx_out_t out_d, out_q;

    prbs_slot_timer #(
        .SLOTS    (SLOTS),
        .SLOT_BITS(SLOT_BITS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .frame_start(frame_start),
        .in_ts0     (in_ts0)
    );

    prbs_lfsr #(
        .W  (LFSR_W),
        .TAP(LFSR_TAP)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(advance),
        .msb    (gen_msb)
    );

    always_comb begin
        out_d   = out_q;
        payload = !framed_mode || !in_ts0;
        advance = bit_en && payload;
        if (bit_en) begin
            out_d.bit_v = payload ? gen_msb : 1'b1;
            out_d.ts0   = !payload;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= TX_OUT_RESET;
        end else begin
            out_q <= out_d;
        end
    end

    assign tx_bit   = out_q.bit_v;
    assign ts0_flag = out_q.ts0;

    // R2: outputs hold while the enable is low
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(tx_bit) && $stable(ts0_flag)));

    // R4: a flagged placeholder bit is always 1
    a_r4_mark_one: assert property (@(posedge clk) disable iff (!rst_n)
        ts0_flag |-> tx_bit);

    // R7: no flag after an unframed bit
    a_r7_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !framed_mode) |=> !ts0_flag);
endmodule

// File: tb/test_prbs_tx_pattern_gen.sv
`timescale 1ns/1ps
module test_prbs_tx_pattern_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic framed_mode = 1'b0;
    logic bit_en = 1'b0;
    logic frame_start = 1'b0;
    logic tx_bit, ts0_flag;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [14:0] ml = '1;
    int          mpos = 0;
    logic        exp_bit = 1'b0;
    logic        exp_flag = 1'b0;
    logic        last_fr = 1'b0;

    always #4 clk = ~clk;

    prbs_tx_pattern_gen i_prbs_tx_pattern_gen (
        .clk(clk), .rst_n(rst_n), .framed_mode(framed_mode),
        .bit_en(bit_en), .frame_start(frame_start),
        .tx_bit(tx_bit), .ts0_flag(ts0_flag)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model, check at next negedge
    task automatic cyc(input logic en, input logic fs, input logic fr);
        string tag;
        int    p;
        logic  pay;
        @(negedge clk);
        bit_en = en; frame_start = fs; framed_mode = fr;
        tag = "R2";
        if (en) begin
            p   = fs ? 0 : mpos;
            pay = !fr || (p >= 8);
            exp_bit  = pay ? ml[14] : 1'b1;
            exp_flag = fr && (p < 8);
            if (pay) ml = {ml[13:0], ml[14] ^ ml[13]};
            mpos = (p + 1) % 256;
            if (fs) tag = "R6";
            else if (fr != last_fr) tag = "R9";
            else if (fr && p < 8) tag = "R4";
            else if (fr) tag = "R5";
            else tag = "R3";
            last_fr = fr;
        end
        @(negedge clk);
        chk(tag, tx_bit, exp_bit, "tx_bit");
        chk((en && !fr) ? "R7" : tag, ts0_flag, exp_flag, "ts0_flag");
        bit_en = 1'b0; frame_start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [14:0] head;
        logic [14:0] tail;
        int          ones;
        head = '0; tail = '0; ones = 0;
        repeat (3) @(negedge clk);
        chk("R1", tx_bit, 1'b0, "tx_bit in reset");
        chk("R1", ts0_flag, 1'b0, "ts0_flag in reset");
        @(negedge clk); rst_n = 1'b1;
        // R1: enables low, outputs stay at reset value
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b1);   // R6: frame_start without enable ignored
        chk("R1", tx_bit, 1'b0, "tx_bit after reset");

        // R3/R8: one full unframed period plus 15 bits
        for (int i = 0; i < 32767 + 15; i++) begin
            cyc(1'b1, 1'b0, 1'b0);
            if (i < 32767 && tx_bit) ones++;
            if (i < 15) head = {head[13:0], tx_bit};
            else if (i >= 32767) tail = {tail[13:0], tx_bit};
        end
        total++;
        if (ones != 16384) begin
            bad++; $display("FAIL R8 ones per period actual=%0d expected=16384", ones);
        end
        total++;
        if (head != tail) begin
            bad++; $display("FAIL R8 period repeat actual=%h expected=%h", tail, head);
        end

        // R4/R5/R9: switch to framed, align, run three frames with gaps
        cyc(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 3 * 256; i++) begin
            cyc(1'b1, 1'b0, 1'b1);
            if (i % 37 == 0) cyc(1'b0, 1'b0, 1'b1);   // R2 gap
        end
        // R6: realign mid-frame
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 300; i++) cyc(1'b1, 1'b0, 1'b1);
        // R9: mode flips inside and outside timeslot 0
        for (int i = 0; i < 600; i++) cyc(1'b1, 1'b0, ((i / 5) % 3) != 0);
        // R6: wrap without frame_start, framed
        for (int i = 0; i < 520; i++) cyc(1'b1, 1'b0, 1'b1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule